// File: doc/BRIEF.md
# Multiplexed-Address DRAM Strobe Sequencer

This block turns single-bit read and write requests into the strobe sequence of an asynchronous DRAM whose address pins are shared between row and column. A requester presents a full cell address, a write flag and a write bit. The sequencer is idle when it accepts the request. It puts the row half of the address on the shared bus and lowers the row strobe. It then switches the bus to the column half and lowers the column strobe. During the column strobe, write enable and output enable are set for the operation. The sensed bit is captured on a read, and the data bit is driven on a write.

After the access, every strobe goes high for a precharge interval. The sequencer then runs a row-only strobe cycle on the same row, which writes the row back into the array. A second precharge follows, and then a one-cycle completion pulse. Every phase length is a parameter counted in controller clock cycles. All strobe and address outputs come from registers, so the DRAM pins see no combinational glitches.

Top module: `dram_seq`

## Requirements
- R1: During reset and in every cycle in which the sequencer is idle, the row, column, write-enable and output-enable strobes are all high (inactive). After reset, ready is 1 and done is 0.
- R2: The bus carries the row half of the address first, which is address bits [19:10] with the default 10-bit row and column. The row strobe falls while the row half is on the bus. The column half, bits [9:0], goes on the bus only after that. The column strobe falls while the column half is on the bus. The column strobe is never low while the row strobe is high, and the bus holds still while only the row strobe is low.
- R3: For a read, write enable stays high while the column strobe is low and output enable is low, and write enable and output enable are never low together.
- R4: For a write, write enable is low while the column strobe is low, output enable stays high, and the write-data pin carries the requested bit.
- R5: The row address is on the bus with all strobes high for T_RSU cycles. The row strobe then falls. The column strobe falls T_RCD cycles after that and stays low for T_CAS cycles. The row strobe stays low for T_RCD+T_CAS cycles in total.
- R6: After the column strobe rises, all strobes stay high for T_PRE cycles. The row strobe then falls alone, with the accessed row address on the bus, for T_REF cycles. This is the write-back refresh of the row. All strobes then stay high for T_PRE more cycles before the access completes.
- R7: Ready is high only while idle. A request is accepted only on a clock edge at which ready is high. A request held on the inputs while ready is low has no effect on the memory.
- R8: Done is a single-cycle pulse. It rises T_RSU+T_RCD+2*T_PRE+T_CAS+T_REF+1 cycles after the accepting edge is observed. Ready returns the cycle after done.
- R9: The read-data output equals the bit stored at the read address from the done pulse of that read. It stays unchanged until the next read completes, and write accesses leave it untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted on this edge |
| req_addr | input | 20 | Cell address, row in upper half |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 1 | Bit to write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 1 | Last read result |
| dram_addr | output | 10 | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dout | output | 1 | Data bit driven to the memory |
| dram_din | input | 1 | Data bit sensed from the memory |

## Verification
The assertions assume that the memory drives a valid sensed bit on dram_din by the last cycle of the column strobe. The bench's behavioural memory does this by updating its output at the falling clock edge right after the column strobe falls. The assertions also assume that reset is held for at least one clock edge before requests start, and the stimulus keeps reset high for several cycles. The requester may hold req_valid high while the sequencer is busy. The stimulus does this on purpose, with a write request to a different address, to show that it is not taken.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_RCD,
    ST_CAS,
    ST_PRE1,
    ST_REF,
    ST_PRE2,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int T_RSU = 2,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_PRE = 2,
  parameter int T_REF = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic op_we,
  output logic accept,
  output logic capture,
  output logic col_sel_nxt,
  output logic ready,
  output logic done,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic oe_n
);
  localparam int TM1  = (T_RSU > T_RCD) ? T_RSU : T_RCD;
  localparam int TM2  = (T_CAS > T_PRE) ? T_CAS : T_PRE;
  localparam int TM3  = (TM1 > TM2) ? TM1 : TM2;
  localparam int TMAX = (TM3 > T_REF) ? TM3 : T_REF;
  localparam int CNT_W = (TMAX > 1) ? $clog2(TMAX) : 1;

  seq_state_e       state_q, state_nxt;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;

  dram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  always_comb begin
    state_nxt = state_q;
    load      = 1'b0;
    load_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        state_nxt = ST_ROW;  load = 1'b1; load_val = CNT_W'(T_RSU - 1);
      end
      ST_ROW: if (expired) begin
        state_nxt = ST_RCD;  load = 1'b1; load_val = CNT_W'(T_RCD - 1);
      end
      ST_RCD: if (expired) begin
        state_nxt = ST_CAS;  load = 1'b1; load_val = CNT_W'(T_CAS - 1);
      end
      ST_CAS: if (expired) begin
        state_nxt = ST_PRE1; load = 1'b1; load_val = CNT_W'(T_PRE - 1);
      end
      ST_PRE1: if (expired) begin
        state_nxt = ST_REF;  load = 1'b1; load_val = CNT_W'(T_REF - 1);
      end
      ST_REF: if (expired) begin
        state_nxt = ST_PRE2; load = 1'b1; load_val = CNT_W'(T_PRE - 1);
      end
      ST_PRE2: if (expired) state_nxt = ST_DONE;
      ST_DONE: state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  assign accept      = (state_q == ST_IDLE) && req_valid;
  assign capture     = (state_q == ST_CAS) && expired && !op_we;
  assign col_sel_nxt = (state_nxt == ST_CAS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ready   <= 1'b1;
      done    <= 1'b0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
    end else begin
      state_q <= state_nxt;
      ready   <= (state_nxt == ST_IDLE);
      done    <= (state_nxt == ST_DONE);
      ras_n   <= !(state_nxt inside {ST_RCD, ST_CAS, ST_REF});
      cas_n   <= !(state_nxt == ST_CAS);
      we_n    <= !((state_nxt == ST_CAS) && op_we);
      oe_n    <= !((state_nxt == ST_CAS) && !op_we);
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid) |=> !ready);
endmodule

// File: rtl/dram_seq_dpath.sv
module dram_seq_dpath #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   accept,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_we,
  input  logic                   req_wdata,
  input  logic                   col_sel_nxt,
  input  logic                   capture,
  input  logic                   dram_din,
  output logic                   op_we,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                   dram_dout,
  output logic                   rd_data
);
  localparam int AW    = ROW_W + COL_W;
  localparam int BUS_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [AW-1:0] addr_q, addr_src;
  logic          wd_q;

  assign addr_src = accept ? req_addr : addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      op_we     <= 1'b0;
      wd_q      <= 1'b0;
      dram_addr <= '0;
      rd_data   <= 1'b0;
    end else begin
      if (accept) begin
        addr_q <= req_addr;
        op_we  <= req_we;
        wd_q   <= req_wdata;
      end
      if (col_sel_nxt) dram_addr <= BUS_W'(addr_src[COL_W-1:0]);
      else             dram_addr <= BUS_W'(addr_src[AW-1:COL_W]);
      if (capture) rd_data <= dram_din;
    end
  end

  assign dram_dout = wd_q;
endmodule

// File: rtl/dram_seq.sv
module dram_seq #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int T_RSU = 2,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_PRE = 2,
  parameter int T_REF = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_we,
  input  logic                   req_wdata,
  output logic                   done,
  output logic                   rd_data,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic                   dram_dout,
  input  logic                   dram_din
);
  logic accept, capture, col_sel_nxt, op_we;

  dram_seq_ctrl #(
    .T_RSU(T_RSU), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_PRE(T_PRE), .T_REF(T_REF)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .op_we       (op_we),
    .accept      (accept),
    .capture     (capture),
    .col_sel_nxt (col_sel_nxt),
    .ready       (req_ready),
    .done        (done),
    .ras_n       (dram_ras_n),
    .cas_n       (dram_cas_n),
    .we_n        (dram_we_n),
    .oe_n        (dram_oe_n)
  );

  dram_seq_dpath #(.ROW_W(ROW_W), .COL_W(COL_W)) u_dpath (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .req_addr    (req_addr),
    .req_we      (req_we),
    .req_wdata   (req_wdata),
    .col_sel_nxt (col_sel_nxt),
    .capture     (capture),
    .dram_din    (dram_din),
    .op_we       (op_we),
    .dram_addr   (dram_addr),
    .dram_dout   (dram_dout),
    .rd_data     (rd_data)
  );

  // R1
  idle_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n));

  // R2
  cas_needs_ras_chk: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n);

  // R2
  row_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dram_ras_n && dram_cas_n && !$past(dram_ras_n) && $past(dram_cas_n))
      |-> $stable(dram_addr));

  // R3
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!dram_we_n && !dram_oe_n));

  // R9
  rd_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_data) |-> $rose(dram_cas_n));
endmodule

// File: tb/sim_dram_seq.sv
module sim_dram_seq;
  localparam int CLK_P = 10;
  localparam int T_RSU = 2, T_RCD = 2, T_CAS = 2, T_PRE = 2, T_REF = 3;
  localparam int LAT = T_RSU + T_RCD + T_CAS + 2*T_PRE + T_REF;

  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, req_we = 1'b0, req_wdata = 1'b0;
  logic [19:0] req_addr = '0;
  logic        req_ready, done, rd_data;
  logic [9:0]  dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dout, dram_din;

  int n_tests = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dram_seq #(.T_RSU(T_RSU), .T_RCD(T_RCD), .T_CAS(T_CAS),
             .T_PRE(T_PRE), .T_REF(T_REF)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dout(dram_dout), .dram_din(dram_din));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural memory array driven by the strobes
  bit        mmem [int];
  bit        ref_mem [int];
  logic [9:0] m_row = '0, m_col = '0;
  logic       m_bit = 1'b0, p_ras = 1'b1, p_cas = 1'b1;

  always @(negedge clk) begin
    if (p_ras && !dram_ras_n) m_row = dram_addr;
    if (p_cas && !dram_cas_n) begin
      m_col = dram_addr;
      if (!dram_we_n) mmem[int'({m_row, dram_addr})] = dram_dout;
      m_bit = mmem.exists(int'({m_row, dram_addr})) ? mmem[int'({m_row, dram_addr})] : 1'b0;
    end
    p_ras = dram_ras_n;
    p_cas = dram_cas_n;
  end
  assign dram_din = (!dram_ras_n && !dram_cas_n && !dram_oe_n) ? m_bit : 1'b0;

  // scoreboard
  bit exp_q[$];
  bit last_rd = 1'b0;

  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
      else begin
        automatic bit e = exp_q.pop_front();
        chk(rd_data == e, "R9 read data at done", int'(rd_data), int'(e));
      end
    end
  end

  task automatic run_req(input logic [19:0] a, input logic w, input logic d,
                         input bit junk, input logic [19:0] junk_a);
    int r1 = 0, c1 = 0, r2 = 0, dn = 0, nfall = 0;
    int w1 = 0, w2 = 0, cw = 0, a_r1 = 0, a_c1 = 0, a_r2 = 0;
    bit weoe_ok = 1'b1, rdy_ok = 1'b1, pre_ok = 1'b1, dout_ok = 1'b1;
    logic pr = 1'b1, pc = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = w; req_wdata = d;
    if (!w) begin
      last_rd = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 1'b0;
    end else begin
      ref_mem[int'(a)] = d;
    end
    exp_q.push_back(last_rd);
    for (int i = 1; i <= LAT + 10; i++) begin
      @(negedge clk);
      if (i == 1) begin
        if (junk) begin
          req_addr = junk_a; req_we = 1'b1; req_wdata = 1'b1;
        end else req_valid = 1'b0;
      end
      if (req_ready && dn == 0) rdy_ok = 1'b0;
      if (pr && !dram_ras_n) begin
        nfall++;
        if (nfall == 1) begin r1 = i; a_r1 = int'(dram_addr); end
        if (nfall == 2) begin r2 = i; a_r2 = int'(dram_addr); end
      end
      if (!dram_ras_n && nfall == 1) w1++;
      if (!dram_ras_n && nfall == 2) w2++;
      if (pc && !dram_cas_n) begin c1 = i; a_c1 = int'(dram_addr); end
      if (!dram_cas_n) begin
        cw++;
        if (w  && !(!dram_we_n && dram_oe_n)) weoe_ok = 1'b0;
        if (!w && !(dram_we_n && !dram_oe_n)) weoe_ok = 1'b0;
        if (w && dram_dout !== d) dout_ok = 1'b0;
      end
      if (nfall == 1 && dram_ras_n && i <= T_RSU + T_RCD + T_CAS + T_PRE &&
          !(dram_cas_n && dram_we_n && dram_oe_n)) pre_ok = 1'b0;
      if (i > T_RSU + T_RCD + T_CAS + T_PRE + T_REF && i <= LAT &&
          !(dram_ras_n && dram_cas_n)) pre_ok = 1'b0;
      pr = dram_ras_n; pc = dram_cas_n;
      if (done) begin
        dn = i;
        req_valid = 1'b0;
        break;
      end
    end
    chk(a_r1 == int'(a[19:10]), "R2 row on bus at row strobe", a_r1, int'(a[19:10]));
    chk(a_c1 == int'(a[9:0]),   "R2 column on bus at column strobe", a_c1, int'(a[9:0]));
    chk(r1 == T_RSU + 1, "R5 row setup length", r1 - 1, T_RSU);
    chk(c1 == T_RSU + T_RCD + 1, "R5 row-to-column delay", c1 - r1, T_RCD);
    chk(cw == T_CAS, "R5 column strobe width", cw, T_CAS);
    chk(w1 == T_RCD + T_CAS, "R5 row strobe width", w1, T_RCD + T_CAS);
    chk(weoe_ok, w ? "R4 write enables" : "R3 read enables", int'(weoe_ok), 1);
    if (w) chk(dout_ok, "R4 write data pin", int'(dout_ok), 1);
    chk(r2 == T_RSU + T_RCD + T_CAS + T_PRE + 1, "R6 refresh start", r2, T_RSU + T_RCD + T_CAS + T_PRE + 1);
    chk(a_r2 == int'(a[19:10]), "R6 refresh row address", a_r2, int'(a[19:10]));
    chk(w2 == T_REF, "R6 refresh width", w2, T_REF);
    chk(nfall == 2, "R6 row strobe count", nfall, 2);
    chk(pre_ok, "R6 precharge strobes high", int'(pre_ok), 1);
    chk(dn == LAT + 1, "R8 done latency", dn, LAT + 1);
    chk(rdy_ok, "R7 ready low while busy", int'(rdy_ok), 1);
    @(negedge clk);
    chk(!done, "R8 done single cycle", int'(done), 0);
    chk(req_ready, "R8 ready after done", int'(req_ready), 1);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes high in reset",
        int'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}), 15);
    chk(req_ready && !done, "R1 ready/done in reset", int'({req_ready, done}), 2);
    rst = 1'b0;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes high idle",
        int'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}), 15);

    run_req(20'h2A5C3, 1'b1, 1'b1, 1'b0, '0);
    run_req(20'h2A5C3, 1'b0, 1'b0, 1'b0, '0);
    run_req(20'h00000, 1'b0, 1'b0, 1'b0, '0);
    // R9: a write after a read leaves rd_data alone
    run_req(20'h00001, 1'b1, 1'b1, 1'b0, '0);
    chk(rd_data == 1'b0, "R9 rd_data held over write", int'(rd_data), 0);
    run_req(20'hFFFFF, 1'b1, 1'b1, 1'b0, '0);
    run_req(20'hFFFFF, 1'b0, 1'b0, 1'b0, '0);
    // R7: write request held during busy must not land
    run_req(20'h12345, 1'b1, 1'b1, 1'b1, 20'h54321);
    run_req(20'h54321, 1'b0, 1'b0, 1'b0, '0);
    run_req(20'h12345, 1'b0, 1'b0, 1'b0, '0);
    run_req(20'h2A5C3, 1'b1, 1'b0, 1'b0, '0);
    run_req(20'h2A5C3, 1'b0, 1'b0, 1'b0, '0);
    run_req(20'h003FF, 1'b0, 1'b0, 1'b0, '0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 every request completed", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule